// File: doc/BRIEF.md
# Wait-State Word Memory Slave on a Pipelined Single-Master Bus

This block is a slave on a pipelined AHB-Lite style bus with a small word-organised memory behind it. A transfer's address and control are captured in one cycle (the address phase). The access is finished in the cycles that follow (the data phase), and those cycles overlap the next transfer's address phase. A parameter sets how many wait cycles each real transfer costs, from 0 to 3. While the slave stalls, it holds its ready output low and does not capture anything new from the bus.

Byte, halfword and word accesses are supported on a 32-bit little-endian data path, so sub-word writes touch only the lanes their address selects. Accesses outside the memory, and sizes wider than the data path, are refused with a two-cycle error response. Idle and busy cycles, and cycles in which the slave is not selected, get an immediate okay response and leave the memory untouched. Burst type, protection and lock attributes play no part.

Top module: `ahb_wait_mem`

## Requirements
- R1: After reset, hreadyout is 1, hresp is 0, hrdata is 0, and every memory word reads back as 0.
- R2: A transfer with htrans[1]=1 (NONSEQ 10 or SEQ 11), hsel=1 and hready_in=1 to a valid address and size is followed by exactly WAIT_STATES data-phase cycles with hreadyout=0. The cycle after those has hreadyout=1 and hresp=0.
- R3: In the final data-phase cycle of a read, hrdata carries the addressed 32-bit word. In every other cycle, hrdata is 0.
- R4: Writes are little-endian and use byte lanes. hsize 0 (byte) writes lane haddr[1:0]. hsize 1 (halfword) writes lanes 1:0 when haddr[1]=0 and lanes 3:2 when haddr[1]=1. hsize 2 (word) writes all four lanes. Lane k is hwdata[8k+7:8k], taken in the final data-phase cycle, and lanes that are not selected keep their old value.
- R5: When hready_in=1 and the slave is not selected or htrans[1]=0 (IDLE 00, BUSY 01), the next cycle has hreadyout=1 and hresp=0, and the memory does not change.
- R6: A selected transfer is refused if its byte address is at or above 4*WORDS, or if its hsize is greater than 2. The slave then gives two cycles of error response, with hresp=1 in both: hreadyout=0 in the first cycle and 1 in the second. Memory does not change.
- R7: While hreadyout is 0, the address and control inputs are not captured. The transfer the master holds is captured on the first edge where the slave is ready. A read issued right behind a write to the same word returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock, rising edge |
| hresetn | input | 1 | Asynchronous reset, active low |
| hsel | input | 1 | Slave select |
| haddr | input | 32 | Byte address |
| htrans | input | 2 | Transfer type: 00 idle, 01 busy, 10 nonsequential, 11 sequential |
| hwrite | input | 1 | 1 = write, 0 = read |
| hsize | input | 3 | 0 byte, 1 halfword, 2 word |
| hwdata | input | 32 | Write data, valid in the data phase |
| hready_in | input | 1 | Bus ready: the previous transfer on the bus is complete |
| hreadyout | output | 1 | Slave ready; 0 inserts a wait cycle |
| hresp | output | 1 | 0 okay, 1 error |
| hrdata | output | 32 | Read data |

## Verification
The bench checks each sub-word write by reading the whole word back. A wrong lane mapping would corrupt a neighbouring byte or put the byte in the wrong position.

It counts the low-ready cycles of every transfer. An extra or missing wait cycle, a one-cycle error, or an error response without a preceding stall would all change that count.

Idle, busy and unselected write attempts are each followed by a read of the same word. A slave that acted on them would show the discarded data.

A read placed directly behind a write to the same word, held through the write's stall, exposes a slave that captures the pending address too early or reads before the write is committed.

// File: rtl/ahbw_pkg.sv
package ahbw_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_ACCESS = 2'd1,
        PH_ERR1   = 2'd2,
        PH_ERR2   = 2'd3
    } phase_e;

    localparam logic [1:0] TR_IDLE   = 2'b00;
    localparam logic [1:0] TR_BUSY   = 2'b01;
    localparam logic [1:0] TR_NONSEQ = 2'b10;
    localparam logic [1:0] TR_SEQ    = 2'b11;

    localparam logic [2:0] SZ_BYTE = 3'd0;
    localparam logic [2:0] SZ_HALF = 3'd1;
    localparam logic [2:0] SZ_WORD = 3'd2;

    localparam int unsigned LANES = 4;

endpackage

// File: rtl/ahbw_lane_dec.sv
module ahbw_lane_dec
    import ahbw_pkg::*;
(
    input  logic [2:0] size_i,
    input  logic [1:0] lo_i,
    output logic [3:0] strb_o,
    output logic       size_ok_o
);

    always_comb begin
        strb_o    = 4'b0000;
        size_ok_o = 1'b1;
        case (size_i)
            SZ_BYTE: strb_o = 4'b0001 << lo_i;
            SZ_HALF: strb_o = lo_i[1] ? 4'b1100 : 4'b0011;
            SZ_WORD: strb_o = 4'b1111;
            default: size_ok_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/ahbw_mem.sv
module ahbw_mem #(
    parameter int unsigned WORDS = 64,
    localparam int unsigned IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [3:0]       strb_i,
    input  logic [31:0]      wdata_i,
    output logic [31:0]      rdata_o
);

    logic [31:0] words_q [WORDS];
    logic [31:0] bmask;

    for (genvar b = 0; b < 4; b++) begin : g_lane
        assign bmask[8*b +: 8] = {8{strb_i[b]}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(WORDS); i++) begin
                words_q[i] <= '0;
            end
        end else if (we_i) begin
            words_q[idx_i] <= (words_q[idx_i] & ~bmask) | (wdata_i & bmask);
        end
    end

    assign rdata_o = words_q[idx_i];

endmodule

// File: rtl/ahbw_ctrl.sv
module ahbw_ctrl
    import ahbw_pkg::*;
#(
    parameter int unsigned IDX_W       = 6,
    parameter int unsigned WAIT_STATES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_i,
    input  logic [1:0]       trans_i,
    input  logic             write_i,
    input  logic             ready_in_i,
    input  logic             addr_ok_i,
    input  logic             size_ok_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [3:0]       strb_i,
    output logic             ready_o,
    output logic             resp_o,
    output logic             we_o,
    output logic             rd_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [3:0]       strb_o
);

    localparam logic [1:0] WAIT_INIT = 2'(WAIT_STATES);

    typedef struct packed {
        phase_e           ph;
        logic [1:0]       cnt;
        logic             wr;
        logic [IDX_W-1:0] idx;
        logic [3:0]       strb;
    } ctrl_t;

    ctrl_t cur_q, nxt_d;
    logic  req_live;
    logic  take_ok;

    always_comb begin
        nxt_d    = cur_q;
        ready_o  = !(cur_q.ph == PH_ERR1) &&
                   !(cur_q.ph == PH_ACCESS && cur_q.cnt != 2'd0);
        resp_o   = (cur_q.ph == PH_ERR1) || (cur_q.ph == PH_ERR2);
        we_o     = (cur_q.ph == PH_ACCESS) && (cur_q.cnt == 2'd0) && cur_q.wr;
        rd_o     = (cur_q.ph == PH_ACCESS) && (cur_q.cnt == 2'd0) && !cur_q.wr;
        req_live = sel_i && trans_i[1];
        take_ok  = 1'b0;

        case (cur_q.ph)
            PH_ACCESS: if (cur_q.cnt != 2'd0) nxt_d.cnt = cur_q.cnt - 2'd1;
            PH_ERR1:   nxt_d.ph = PH_ERR2;
            default:   ;
        endcase

        if (ready_o) begin
            if (ready_in_i && req_live) begin
                if (addr_ok_i && size_ok_i) begin
                    take_ok    = 1'b1;
                    nxt_d.ph   = PH_ACCESS;
                    nxt_d.cnt  = WAIT_INIT;
                    nxt_d.wr   = write_i;
                    nxt_d.idx  = idx_i;
                    nxt_d.strb = strb_i;
                end else begin
                    nxt_d.ph  = PH_ERR1;
                    nxt_d.cnt = 2'd0;
                end
            end else begin
                nxt_d.ph  = PH_IDLE;
                nxt_d.cnt = 2'd0;
            end
        end

        idx_o  = cur_q.idx;
        strb_o = cur_q.strb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{ph: PH_IDLE, cnt: 2'd0, wr: 1'b0, idx: '0, strb: 4'b0000};
        end else begin
            cur_q <= nxt_d;
        end
    end

    // R2: the first data-phase cycle stalls exactly when wait cycles are configured
    p_wait_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take_ok |=> (ready_o == (WAIT_STATES == 0)) && !resp_o);

    // R5: idle, busy or unselected cycles answer at once with okay
    p_idle_okay_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && ready_in_i && !req_live) |=> (ready_o && !resp_o && !we_o));

    // R6: an error stall cycle is always followed by the completing error cycle
    p_err_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_o && !ready_o) |=> (resp_o && ready_o));

    // R7: the captured transfer does not move while the slave stalls
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_o && cur_q.ph == PH_ACCESS) |=>
            ($stable(idx_o) && $stable(strb_o) && $stable(cur_q.wr)));

endmodule

// File: rtl/ahb_wait_mem.sv
module ahb_wait_mem
    import ahbw_pkg::*;
#(
    parameter int unsigned WORDS       = 64,
    parameter int unsigned WAIT_STATES = 2,
    localparam int unsigned IDX_W      = $clog2(WORDS)
) (
    input  logic        hclk,
    input  logic        hresetn,
    input  logic        hsel,
    input  logic [31:0] haddr,
    input  logic [1:0]  htrans,
    input  logic        hwrite,
    input  logic [2:0]  hsize,
    input  logic [31:0] hwdata,
    input  logic        hready_in,
    output logic        hreadyout,
    output logic        hresp,
    output logic [31:0] hrdata
);

    logic [3:0]       strb_in;
    logic             size_ok;
    logic             addr_ok;
    logic             mem_we;
    logic             mem_rd;
    logic [IDX_W-1:0] cap_idx;
    logic [3:0]       cap_strb;
    logic [31:0]      mem_rdata;

    assign addr_ok = (haddr[31:IDX_W+2] == '0);

    ahbw_lane_dec u_lane (
        .size_i    (hsize),
        .lo_i      (haddr[1:0]),
        .strb_o    (strb_in),
        .size_ok_o (size_ok)
    );

    ahbw_ctrl #(
        .IDX_W       (IDX_W),
        .WAIT_STATES (WAIT_STATES)
    ) u_ctrl (
        .clk        (hclk),
        .rst_n      (hresetn),
        .sel_i      (hsel),
        .trans_i    (htrans),
        .write_i    (hwrite),
        .ready_in_i (hready_in),
        .addr_ok_i  (addr_ok),
        .size_ok_i  (size_ok),
        .idx_i      (haddr[IDX_W+1:2]),
        .strb_i     (strb_in),
        .ready_o    (hreadyout),
        .resp_o     (hresp),
        .we_o       (mem_we),
        .rd_o       (mem_rd),
        .idx_o      (cap_idx),
        .strb_o     (cap_strb)
    );

    ahbw_mem #(
        .WORDS (WORDS)
    ) u_mem (
        .clk     (hclk),
        .rst_n   (hresetn),
        .we_i    (mem_we),
        .idx_i   (cap_idx),
        .strb_i  (cap_strb),
        .wdata_i (hwdata),
        .rdata_o (mem_rdata)
    );

    assign hrdata = mem_rd ? mem_rdata : 32'h0;

    // R3: read data stays quiet while the slave stalls
    p_rdata_quiet_r3: assert property (@(posedge hclk) disable iff (!hresetn)
        !hreadyout |-> (hrdata == 32'h0));

    // R4: a byte access enables exactly one lane
    p_byte_lane_r4: assert property (@(posedge hclk) disable iff (!hresetn)
        (hsize == SZ_BYTE) |-> ($countones(strb_in) == 1));

    // R6: no memory write during an error response
    p_err_nowrite_r6: assert property (@(posedge hclk) disable iff (!hresetn)
        hresp |-> !mem_we);

endmodule

// File: tb/ahb_wait_mem_tb.sv
module ahb_wait_mem_tb;

    localparam int unsigned WAITS = 2;

    logic        hclk = 1'b0;
    logic        hresetn = 1'b0;
    logic        hsel = 1'b0;
    logic [31:0] haddr = '0;
    logic [1:0]  htrans = 2'b00;
    logic        hwrite = 1'b0;
    logic [2:0]  hsize = 3'd2;
    logic [31:0] hwdata = '0;
    logic        hready_in;
    logic        hreadyout;
    logic        hresp;
    logic [31:0] hrdata;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    assign hready_in = hreadyout;

    always #4 hclk = ~hclk;

    ahb_wait_mem #(.WORDS(64), .WAIT_STATES(WAITS)) u_dut (
        .hclk      (hclk),
        .hresetn   (hresetn),
        .hsel      (hsel),
        .haddr     (haddr),
        .htrans    (htrans),
        .hwrite    (hwrite),
        .hsize     (hsize),
        .hwdata    (hwdata),
        .hready_in (hready_in),
        .hreadyout (hreadyout),
        .hresp     (hresp),
        .hrdata    (hrdata)
    );

    typedef struct packed {
        logic        wr;
        logic [2:0]  sz;
        logic [31:0] addr;
        logic [31:0] wd;
        logic [31:0] exp;
        logic        err;
    } vec_t;

    localparam vec_t VECS [16] = '{
        '{1'b1, 3'd2, 32'h00, 32'h11223344, 32'h0,        1'b0}, // R2 word write
        '{1'b0, 3'd2, 32'h00, 32'h0,        32'h11223344, 1'b0}, // R3
        '{1'b1, 3'd0, 32'h01, 32'h0000AA00, 32'h0,        1'b0}, // R4 byte lane 1
        '{1'b0, 3'd2, 32'h00, 32'h0,        32'h1122AA44, 1'b0},
        '{1'b1, 3'd1, 32'h02, 32'hBEEF0000, 32'h0,        1'b0}, // R4 upper half
        '{1'b0, 3'd2, 32'h00, 32'h0,        32'hBEEFAA44, 1'b0},
        '{1'b1, 3'd0, 32'h03, 32'h77000000, 32'h0,        1'b0}, // R4 byte lane 3
        '{1'b0, 3'd2, 32'h00, 32'h0,        32'h77EFAA44, 1'b0},
        '{1'b1, 3'd2, 32'hFC, 32'hCAFEF00D, 32'h0,        1'b0}, // last word
        '{1'b0, 3'd2, 32'hFC, 32'h0,        32'hCAFEF00D, 1'b0},
        '{1'b1, 3'd2, 32'h100,32'h12345678, 32'h0,        1'b1}, // R6 range
        '{1'b0, 3'd2, 32'h100,32'h0,        32'h0,        1'b1},
        '{1'b1, 3'd3, 32'h08, 32'hFFFFFFFF, 32'h0,        1'b1}, // R6 size
        '{1'b0, 3'd2, 32'h08, 32'h0,        32'h0,        1'b0},
        '{1'b1, 3'd1, 32'h04, 32'h00001234, 32'h0,        1'b0}, // R4 lower half
        '{1'b0, 3'd2, 32'h04, 32'h0,        32'h00001234, 1'b0}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic xfer(input logic wr, input logic [2:0] sz, input logic [31:0] addr,
                        input logic [31:0] wd, input logic [31:0] exp, input logic err,
                        input string req);
        int  waits;
        bit  quiet;
        @(negedge hclk);
        hsel = 1'b1; htrans = 2'b10; hwrite = wr; hsize = sz; haddr = addr;
        @(negedge hclk);
        hsel = 1'b0; htrans = 2'b00; hwdata = wd;
        waits = 0; quiet = 1'b1;
        while (!hreadyout && waits < 10) begin
            waits++;
            if (hrdata != 32'h0) quiet = 1'b0;
            @(negedge hclk);
        end
        check(waits == (err ? 1 : int'(WAITS)), req, "wait cycles", 32'(waits),
              32'(err ? 1 : WAITS));
        check(hresp == err, req, "response", 32'(hresp), 32'(err));
        check(quiet, "R3", "hrdata quiet during stall", 32'(quiet), 32'h1);
        if (!wr && !err) check(hrdata == exp, req, "read data", hrdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge hclk);
        hresetn = 1'b1;
        @(negedge hclk);
        check(hreadyout == 1'b1, "R1", "ready after reset", 32'(hreadyout), 32'h1);
        check(hresp == 1'b0, "R1", "resp after reset", 32'(hresp), 32'h0);
        check(hrdata == 32'h0, "R1", "rdata after reset", hrdata, 32'h0);
        xfer(1'b0, 3'd2, 32'h10, 32'h0, 32'h0, 1'b0, "R1");

        for (int i = 0; i < 16; i++) begin
            xfer(VECS[i].wr, VECS[i].sz, VECS[i].addr, VECS[i].wd,
                 VECS[i].exp, VECS[i].err, VECS[i].wr ? "R4" : "R3");
        end

        // R5: BUSY write attempt is ignored and answered at once
        @(negedge hclk);
        hsel = 1'b1; htrans = 2'b01; hwrite = 1'b1; hsize = 3'd2; haddr = 32'h20;
        @(negedge hclk);
        hsel = 1'b0; htrans = 2'b00; hwdata = 32'hDEADBEEF;
        check(hreadyout && !hresp, "R5", "busy okay", {hreadyout, hresp}, 32'h2);
        xfer(1'b0, 3'd2, 32'h20, 32'h0, 32'h0, 1'b0, "R5");

        // R5: unselected NONSEQ write is ignored
        @(negedge hclk);
        hsel = 1'b0; htrans = 2'b10; hwrite = 1'b1; hsize = 3'd2; haddr = 32'h24;
        @(negedge hclk);
        htrans = 2'b00; hwdata = 32'hA5A5A5A5;
        check(hreadyout && !hresp, "R5", "unselected okay", {hreadyout, hresp}, 32'h2);
        xfer(1'b0, 3'd2, 32'h24, 32'h0, 32'h0, 1'b0, "R5");

        // R7: read held behind a stalled write to the same word
        begin
            int waits;
            @(negedge hclk);
            hsel = 1'b1; htrans = 2'b10; hwrite = 1'b1; hsize = 3'd2; haddr = 32'h30;
            @(negedge hclk);
            hwrite = 1'b0; haddr = 32'h30; hwdata = 32'h5A5A1234;
            waits = 0;
            while (!hreadyout && waits < 10) begin waits++; @(negedge hclk); end
            check(waits == int'(WAITS), "R7", "write stall", 32'(waits), 32'(WAITS));
            @(negedge hclk);
            hsel = 1'b0; htrans = 2'b00; hwdata = 32'h0;
            waits = 0;
            while (!hreadyout && waits < 10) begin waits++; @(negedge hclk); end
            check(waits == int'(WAITS), "R7", "read stall", 32'(waits), 32'(WAITS));
            check(hrdata == 32'h5A5A1234, "R7", "read after write", hrdata, 32'h5A5A1234);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge hclk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule